// File: doc/BRIEF.md
# Peer Setup Message Parser

This block sits behind the receive side of a control link from a coordinating server. The link delivers one byte per cycle, and a sideband flag shows whether a message carries a handle. The block packs the bytes into 64-bit messages in little-endian order. It then runs a fixed setup handshake: a protocol version message first, then the block's own ID, then any number of peer messages, and finally the shared-memory message, which completes setup.

After the ID message the block keeps one vector counter per peer. Vector numbers never travel on the link. Each connect (a peer number sent with a handle) implies the next vector of that peer, and the block reports it with a one-cycle table-update strobe that carries the peer and the vector. When the peer is the block itself, a local-vector-ready strobe is raised as well. A disconnect (a peer number sent without a handle) clears the peer's counter. Protocol violations raise a sticky error flag. If the violation happens before setup completes, the handshake is abandoned for good.

Top module: `peer_setup_parser`

## Requirements
- R1: A message is eight bytes accepted on `byteValid`. Byte k lands in bits 8k+7..8k. Any number of idle cycles may separate the bytes. The handle flag is taken only together with the eighth byte.
- R2: The first message must equal `PROTO_VER` (default 0) and must have no handle. Otherwise `errFlag` sets and setup never completes.
- R3: The second message is the own ID. It must have no handle and bits 63..16 must be zero. Its value then appears on `ownId`. Otherwise `errFlag` sets and setup never completes.
- R4: After the ID, a message with bits 63..16 zero, a handle, and a value below `MAX_PEERS` is a connect. It gives exactly one one-cycle `tblUpd` pulse. `tblPeer` carries the value, and `tblVec` carries the number of connects accepted for that peer since reset or since its last disconnect.
- R5: A connect naming the own ID also pulses `localRdy` in the same cycle, with `localVec` equal to `tblVec`.
- R6: A connect that finds the peer already holding `NUM_VECS` vectors, or that names a peer at or above `MAX_PEERS`, gives no strobe, leaves the count unchanged and sets `errFlag`.
- R7: A disconnect clears that peer's count, so the next connect for it gets vector 0. A disconnect naming the own ID, or a peer at or above `MAX_PEERS`, sets `errFlag` instead.
- R8: The all-ones message (shared memory) raises `setupDone` one cycle after it is classified, and `setupDone` then holds. A further all-ones message after that sets `errFlag`.
- R9: A message that is not all ones and has any of bits 63..16 set is invalid and sets `errFlag`.
- R10: `errFlag` stays set until reset. Any error raised before `setupDone` abandons setup: every later message is ignored, with no strobe and no `setupDone`.
- R11: After reset all outputs are zero and every peer count is zero.
- R12: An error raised after `setupDone` does not stop processing, so later valid connects still produce strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteValid | input | 1 | A byte is presented this cycle |
| byteData | input | 8 | Message byte |
| handleIn | input | 1 | Handle present; sampled with the eighth byte |
| ownId | output | 16 | Own ID accepted during setup |
| setupDone | output | 1 | Handshake finished |
| errFlag | output | 1 | Sticky protocol error |
| tblUpd | output | 1 | One-cycle pulse: a peer gained a vector |
| tblPeer | output | 16 | Peer of the latest update |
| tblVec | output | VW | Vector index of the latest update |
| localRdy | output | 1 | One-cycle pulse: a vector of the own ID became ready |
| localVec | output | VW | Vector index of the local update |

## Verification
Classifying a completed message and accepting the first byte of the next message can happen in the same cycle. In that cycle the table counter and the byte lane being overwritten change at the same edge. The bench provokes this by sending pairs of messages with no idle cycle between them, both during fixed scenarios and at random within a long stream. It then judges the overlap by requiring both update strobes, the vector taken by the second one, and the error flag all to match the model that is applied to the two messages in order.

// File: rtl/peer_setup_pkg.sv
package peer_setup_pkg;
  localparam int MSG_W  = 64;
  localparam int PEER_W = 16;

  typedef enum logic [2:0] {
    ST_VER,
    ST_ID,
    ST_RUN,
    ST_DONE,
    ST_FAIL
  } setupState_t;

  // strobes from control to the datapath table
  typedef struct packed {
    logic              incCnt;
    logic              clrCnt;
    logic [PEER_W-1:0] peer;
  } tblCmd_t;
endpackage

// File: rtl/peer_setup_dp.sv
module peer_setup_dp
  import peer_setup_pkg::*;
#(
  parameter int MAX_PEERS = 32,
  parameter int NUM_VECS  = 4,
  localparam int CW = $clog2(NUM_VECS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             byteValid,
  input  logic [7:0]       byteData,
  input  logic             handleIn,
  input  tblCmd_t          cmd,
  output logic             msgValid,
  output logic [MSG_W-1:0] msgWord,
  output logic             msgHandle,
  output logic [CW-1:0]    selCount
);
  localparam int LANES = MSG_W / 8;
  localparam int LW    = $clog2(LANES);
  localparam int IW    = (MAX_PEERS > 1) ? $clog2(MAX_PEERS) : 1;

  logic [LW-1:0] laneSel;
  logic          lastLane;

  assign lastLane = (laneSel == LW'(LANES - 1));

  // byte position counter; wraps after the last lane
  always_ff @(posedge clk) begin
    if (!rstN) begin
      laneSel   <= '0;
      msgValid  <= 1'b0;
      msgHandle <= 1'b0;
    end else begin
      msgValid <= byteValid && lastLane;
      if (byteValid) begin
        laneSel <= laneSel + 1'b1;
        if (lastLane) msgHandle <= handleIn;
      end
    end
  end

  // one register per byte lane, little-endian placement
  for (genvar lane = 0; lane < LANES; lane++) begin : gLane
    logic [7:0] laneReg;
    always_ff @(posedge clk) begin
      if (!rstN) laneReg <= '0;
      else if (byteValid && laneSel == LW'(lane)) laneReg <= byteData;
    end
    assign msgWord[lane*8 +: 8] = laneReg;
  end

  // per-peer vector counters
  logic [CW-1:0] cntArr [MAX_PEERS];

  for (genvar p = 0; p < MAX_PEERS; p++) begin : gPeer
    logic [CW-1:0] cnt;
    logic          hit;
    assign hit = (cmd.peer == PEER_W'(p));
    always_ff @(posedge clk) begin
      if (!rstN) cnt <= '0;
      else if (cmd.clrCnt && hit) cnt <= '0;
      else if (cmd.incCnt && hit) cnt <= cnt + 1'b1;
    end
    assign cntArr[p] = cnt;
  end

  // count of the peer named by the message now on msgWord
  always_comb begin
    selCount = '0;
    for (int p = 0; p < MAX_PEERS; p++) begin
      if (msgWord[IW-1:0] == IW'(p)) selCount = cntArr[p];
    end
  end
endmodule

// File: rtl/peer_setup_ctl.sv
module peer_setup_ctl
  import peer_setup_pkg::*;
#(
  parameter int              MAX_PEERS = 32,
  parameter int              NUM_VECS  = 4,
  parameter logic [MSG_W-1:0] PROTO_VER = 64'd0,
  localparam int CW = $clog2(NUM_VECS + 1),
  localparam int VW = (NUM_VECS > 1) ? $clog2(NUM_VECS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              msgValid,
  input  logic [MSG_W-1:0]  msgWord,
  input  logic              msgHandle,
  input  logic [CW-1:0]     selCount,
  output tblCmd_t           cmd,
  output logic [PEER_W-1:0] ownId,
  output logic              setupDone,
  output logic              errFlag,
  output logic              tblUpd,
  output logic [PEER_W-1:0] tblPeer,
  output logic [VW-1:0]     tblVec,
  output logic              localRdy,
  output logic [VW-1:0]     localVec
);
  setupState_t       state, stateNxt;
  logic              isShm, upperZero, inTable, isFull, isOwn;
  logic              doConn, doDisc, msgErr, idOk;
  logic [PEER_W-1:0] peerNum;

  always_comb begin
    isShm     = &msgWord;
    upperZero = (msgWord[MSG_W-1:PEER_W] == '0);
    peerNum   = msgWord[PEER_W-1:0];
    inTable   = (int'(peerNum) < MAX_PEERS);
    isFull    = (selCount == CW'(NUM_VECS));
    isOwn     = (peerNum == ownId);
    stateNxt  = state;
    msgErr    = 1'b0;
    doConn    = 1'b0;
    doDisc    = 1'b0;
    idOk      = 1'b0;
    if (msgValid) begin
      case (state)
        ST_VER: begin
          if (msgWord != PROTO_VER || msgHandle) begin
            msgErr   = 1'b1;
            stateNxt = ST_FAIL;
          end else begin
            stateNxt = ST_ID;
          end
        end
        ST_ID: begin
          if (msgHandle || !upperZero) begin
            msgErr   = 1'b1;
            stateNxt = ST_FAIL;
          end else begin
            idOk     = 1'b1;
            stateNxt = ST_RUN;
          end
        end
        ST_RUN, ST_DONE: begin
          if (isShm) begin
            if (state == ST_RUN) stateNxt = ST_DONE;
            else msgErr = 1'b1;
          end else if (!upperZero || !inTable) begin
            msgErr = 1'b1;
          end else if (msgHandle) begin
            if (isFull) msgErr = 1'b1;
            else doConn = 1'b1;
          end else if (isOwn) begin
            msgErr = 1'b1;
          end else begin
            doDisc = 1'b1;
          end
          if (msgErr && state == ST_RUN) stateNxt = ST_FAIL;
        end
        default: ;
      endcase
    end
    cmd.incCnt = doConn;
    cmd.clrCnt = doDisc;
    cmd.peer   = peerNum;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_VER;
      ownId     <= '0;
      setupDone <= 1'b0;
      errFlag   <= 1'b0;
      tblUpd    <= 1'b0;
      tblPeer   <= '0;
      tblVec    <= '0;
      localRdy  <= 1'b0;
      localVec  <= '0;
    end else begin
      state     <= stateNxt;
      setupDone <= (stateNxt == ST_DONE);
      errFlag   <= errFlag | msgErr;
      tblUpd    <= doConn;
      localRdy  <= doConn && isOwn;
      if (idOk) ownId <= peerNum;
      if (doConn) begin
        tblPeer <= peerNum;
        tblVec  <= selCount[VW-1:0];
        if (isOwn) localVec <= selCount[VW-1:0];
      end
    end
  end
endmodule

// File: rtl/peer_setup_parser.sv
module peer_setup_parser
  import peer_setup_pkg::*;
#(
  parameter int              MAX_PEERS = 32,
  parameter int              NUM_VECS  = 4,
  parameter logic [MSG_W-1:0] PROTO_VER = 64'd0,
  localparam int CW = $clog2(NUM_VECS + 1),
  localparam int VW = (NUM_VECS > 1) ? $clog2(NUM_VECS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteValid,
  input  logic [7:0]        byteData,
  input  logic              handleIn,
  output logic [PEER_W-1:0] ownId,
  output logic              setupDone,
  output logic              errFlag,
  output logic              tblUpd,
  output logic [PEER_W-1:0] tblPeer,
  output logic [VW-1:0]     tblVec,
  output logic              localRdy,
  output logic [VW-1:0]     localVec
);
  tblCmd_t          cmd;
  logic             msgValid;
  logic [MSG_W-1:0] msgWord;
  logic             msgHandle;
  logic [CW-1:0]    selCount;

  peer_setup_dp #(
    .MAX_PEERS(MAX_PEERS),
    .NUM_VECS (NUM_VECS)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .byteValid(byteValid),
    .byteData (byteData),
    .handleIn (handleIn),
    .cmd      (cmd),
    .msgValid (msgValid),
    .msgWord  (msgWord),
    .msgHandle(msgHandle),
    .selCount (selCount)
  );

  peer_setup_ctl #(
    .MAX_PEERS(MAX_PEERS),
    .NUM_VECS (NUM_VECS),
    .PROTO_VER(PROTO_VER)
  ) uCtl (
    .clk      (clk),
    .rstN     (rstN),
    .msgValid (msgValid),
    .msgWord  (msgWord),
    .msgHandle(msgHandle),
    .selCount (selCount),
    .cmd      (cmd),
    .ownId    (ownId),
    .setupDone(setupDone),
    .errFlag  (errFlag),
    .tblUpd   (tblUpd),
    .tblPeer  (tblPeer),
    .tblVec   (tblVec),
    .localRdy (localRdy),
    .localVec (localVec)
  );
endmodule

// File: rtl/peer_setup_chk.sv
module peer_setup_chk #(
  parameter int MAX_PEERS = 32
) (
  input logic        clk,
  input logic        rstN,
  input logic        setupDone,
  input logic        errFlag,
  input logic        tblUpd,
  input logic        localRdy,
  input logic [15:0] tblPeer,
  input logic [15:0] ownId
);
  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);

  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    setupDone |=> setupDone);

  // R10
  done_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(setupDone) |-> !errFlag);

  // R5
  local_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    localRdy |-> (tblUpd && tblPeer == ownId));

  // R4
  upd_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    tblUpd |=> !tblUpd);

  // R6
  peer_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    tblUpd |-> (int'(tblPeer) < MAX_PEERS));
endmodule

bind peer_setup_parser peer_setup_chk #(.MAX_PEERS(MAX_PEERS)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .setupDone(setupDone),
  .errFlag  (errFlag),
  .tblUpd   (tblUpd),
  .localRdy (localRdy),
  .tblPeer  (tblPeer),
  .ownId    (ownId)
);

// File: tb/sim_peer_setup_parser.sv
module sim_peer_setup_parser;
  localparam int          MP  = 32;
  localparam int          NV  = 4;
  localparam logic [63:0] VER = 64'd0;
  localparam logic [63:0] SHM = 64'hFFFF_FFFF_FFFF_FFFF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        byteValid = 1'b0;
  logic [7:0]  byteData = '0;
  logic        handleIn = 1'b0;
  logic [15:0] ownId, tblPeer;
  logic        setupDone, errFlag, tblUpd, localRdy;
  logic [1:0]  tblVec, localVec;

  always #10 clk = ~clk;

  peer_setup_parser #(.MAX_PEERS(MP), .NUM_VECS(NV), .PROTO_VER(VER)) u0 (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteData(byteData),
    .handleIn(handleIn), .ownId(ownId), .setupDone(setupDone),
    .errFlag(errFlag), .tblUpd(tblUpd), .tblPeer(tblPeer), .tblVec(tblVec),
    .localRdy(localRdy), .localVec(localVec)
  );

  int nChk = 0;
  int nFail = 0;

  // strobe monitor, sampled away from the active edge
  int          updSeen = 0, locSeen = 0;
  logic [15:0] seenPeer = '0;
  logic [1:0]  seenVec = '0, seenLoc = '0;
  always @(negedge clk) begin
    if (tblUpd) begin updSeen++; seenPeer = tblPeer; seenVec = tblVec; end
    if (localRdy) begin locSeen++; seenLoc = localVec; end
  end

  // model state: 0 version, 1 id, 2 collect, 3 done, 4 failed
  int          mState;
  logic [15:0] mOwn;
  int          mCnt [MP];
  bit          mErr, mDone;
  int          expUpd, expLoc;
  logic [15:0] expPeer;
  logic [1:0]  expVec, expLocVec;

  task automatic chk(bit ok, string tag, string scen, longint act, longint exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s [%s] actual=%0d expected=%0d", tag, scen, act, exp);
    end
  endtask

  task automatic modelApply(logic [63:0] v, bit h);
    bit          isShm = &v;
    bit          upZ = (v[63:16] == '0);
    logic [15:0] peer = v[15:0];
    bit          e = 1'b0;
    case (mState)
      0: if (v != VER || h) begin mErr = 1; mState = 4; end else mState = 1;
      1: if (h || !upZ) begin mErr = 1; mState = 4; end
         else begin mOwn = peer; mState = 2; end
      2, 3: begin
        if (isShm) begin
          if (mState == 2) begin mState = 3; mDone = 1; end else e = 1;
        end else if (!upZ || int'(peer) >= MP) e = 1;
        else if (h) begin
          if (mCnt[peer] == NV) e = 1;
          else begin
            expUpd++; expPeer = peer; expVec = 2'(mCnt[peer]);
            if (peer == mOwn) begin expLoc++; expLocVec = 2'(mCnt[peer]); end
            mCnt[peer]++;
          end
        end else if (peer == mOwn) e = 1;
        else mCnt[peer] = 0;
        if (e) begin mErr = 1; if (mState == 2) mState = 4; end
      end
      default: ;
    endcase
  endtask

  // R1: the handle is only meaningful on the last byte; drive its inverse before
  task automatic sendRaw(logic [63:0] v, bit h, int gapMax);
    for (int b = 0; b < 8; b++) begin
      @(negedge clk);
      byteValid = 1'b1;
      byteData  = v[8*b +: 8];
      handleIn  = (b == 7) ? h : ~h;
      if (b != 7 && gapMax > 0) begin
        int gap = $urandom_range(gapMax, 0);
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          byteValid = 1'b0;
        end
      end
    end
  endtask

  task automatic endBytes();
    @(negedge clk);
    byteValid = 1'b0;
    handleIn  = 1'b0;
  endtask

  task automatic verify(string scen);
    repeat (3) @(negedge clk);
    #1;
    chk(updSeen == expUpd, "R4", scen, updSeen, expUpd);
    if (updSeen == expUpd && expUpd > 0) begin
      chk(seenPeer == expPeer, "R4", scen, seenPeer, expPeer);
      chk(seenVec == expVec, "R4", scen, seenVec, expVec);
    end
    chk(locSeen == expLoc, "R5", scen, locSeen, expLoc);
    if (locSeen == expLoc && expLoc > 0)
      chk(seenLoc == expLocVec, "R5", scen, seenLoc, expLocVec);
    chk(errFlag == mErr, "R10", scen, errFlag, mErr);
    chk(setupDone == mDone, "R8", scen, setupDone, mDone);
    chk(ownId == mOwn, "R3", scen, ownId, mOwn);
  endtask

  task automatic sendMsg(logic [63:0] v, bit h, int gapMax, string scen);
    sendRaw(v, h, gapMax);
    endBytes();
    modelApply(v, h);
    verify(scen);
  endtask

  task automatic sendPair(logic [63:0] a, bit ha, logic [63:0] b, bit hb, string scen);
    sendRaw(a, ha, 0);
    sendRaw(b, hb, 0);
    endBytes();
    modelApply(a, ha);
    modelApply(b, hb);
    verify(scen);
  endtask

  task automatic doReset(string scen);
    @(negedge clk);
    rstN = 1'b0;
    byteValid = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    mState = 0; mOwn = '0; mErr = 0; mDone = 0;
    for (int p = 0; p < MP; p++) mCnt[p] = 0;
    @(negedge clk);
    #1;
    expUpd = updSeen; expLoc = locSeen;
    // R11: reset state
    chk({ownId, setupDone, errFlag, tblUpd, localRdy, tblPeer, tblVec, localVec} == '0,
        "R11", scen, {setupDone, errFlag, tblUpd, localRdy}, 0);
  endtask

  task automatic setupOk(logic [15:0] id, string scen);
    sendMsg(VER, 0, 1, scen);
    sendMsg({48'd0, id}, 0, 1, scen);
    sendMsg(SHM, 0, 1, scen);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    doReset("R11 reset");

    // R2: wrong version, then a shared-memory message must be ignored (R10)
    sendMsg(VER + 1, 0, 0, "R2 bad version");
    sendMsg(SHM, 0, 0, "R10 ignored after fail");
    doReset("R11 reset");
    sendMsg(VER, 1, 0, "R2 version with handle");

    // R3: id above 65535, then id with handle
    doReset("R11 reset");
    sendMsg(VER, 0, 0, "R3 setup");
    sendMsg(64'd70000, 0, 0, "R3 id out of range");
    doReset("R11 reset");
    sendMsg(VER, 0, 0, "R3 setup");
    sendMsg(64'd5, 1, 0, "R3 id with handle");

    // R1: byte order with gaps
    doReset("R11 reset");
    sendMsg(VER, 0, 3, "R1 gaps");
    sendMsg(64'h0000_0000_0000_A55A, 0, 3, "R1 id byte order");
    sendMsg(SHM, 0, 3, "R8 done");

    // R9 and R10: invalid value during setup abandons it
    doReset("R11 reset");
    sendMsg(VER, 0, 0, "R9 setup");
    sendMsg(64'd2, 0, 0, "R9 setup");
    sendMsg(64'h0000_0001_0000_0007, 1, 0, "R9 invalid in setup");
    sendMsg(64'd7, 1, 0, "R10 connect ignored");
    sendMsg(SHM, 0, 0, "R10 no done");

    // R4/R5: connects during setup, then completion
    doReset("R11 reset");
    sendMsg(VER, 0, 1, "R4 setup");
    sendMsg(64'd3, 0, 1, "R4 setup");
    sendMsg(64'd3, 1, 1, "R5 own vec0");
    sendMsg(64'd3, 1, 1, "R5 own vec1");
    sendMsg(64'd7, 1, 1, "R4 peer7 vec0");
    sendMsg(64'd7, 1, 1, "R4 peer7 vec1");
    sendMsg(SHM, 0, 1, "R8 done");
    // R7: disconnect clears count
    sendMsg(64'd7, 0, 1, "R7 disconnect");
    sendMsg(64'd7, 1, 1, "R7 reconnect vec0");
    // back-to-back classification and byte accept overlap
    sendPair(64'd9, 1, 64'd9, 1, "R4 back-to-back");
    // R8: second shared-memory message
    sendMsg(SHM, 0, 0, "R8 second shm");
    // R12: processing continues after error
    sendMsg(64'd9, 1, 0, "R12 after error");

    // R6: overflow after done
    doReset("R11 reset");
    setupOk(16'd1, "R6 setup");
    for (int i = 0; i < NV; i++) sendMsg(64'd12, 1, 0, "R6 fill");
    sendMsg(64'd12, 1, 0, "R6 overflow");
    sendMsg(64'd12, 1, 0, "R6 still full");
    sendMsg(64'd13, 1, 0, "R12 other peer");

    // R6: connect beyond table
    doReset("R11 reset");
    setupOk(16'd1, "R6 setup");
    sendMsg(64'd40, 1, 0, "R6 peer beyond table");

    // R7: disconnect of own id / out of table
    doReset("R11 reset");
    setupOk(16'd4, "R7 setup");
    sendMsg(64'd4, 1, 0, "R5 own after done");
    sendMsg(64'd4, 0, 0, "R7 disconnect own");
    sendMsg(64'd4, 1, 0, "R7 own count kept");
    doReset("R11 reset");
    setupOk(16'd4, "R7 setup");
    sendMsg(64'd35, 0, 0, "R7 disconnect beyond table");

    // R9: minus two after done
    doReset("R11 reset");
    setupOk(16'd0, "R9 setup");
    sendMsg(64'hFFFF_FFFF_FFFF_FFFE, 0, 0, "R9 minus two");
    sendMsg(64'd0, 1, 0, "R12 own after error");

    // random stream
    doReset("R11 reset");
    setupOk(16'd6, "R4 random setup");
    for (int i = 0; i < 300; i++) begin
      int          r = $urandom_range(99);
      logic [63:0] v;
      bit          h = ($urandom_range(99) < 70);
      if (r < 4) v = {16'h0, 16'($urandom_range(65535)), 32'h0} | 64'h0001_0000_0000;
      else if (r < 6) v = SHM;
      else v = 64'($urandom_range(MP + 3));
      if ($urandom_range(9) == 0)
        sendPair(v, h, 64'($urandom_range(MP - 1)), 1'b1, "R4 random pair");
      else
        sendMsg(v, h, $urandom_range(2), "R4 random");
    end

    $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end
endmodule